// File: doc/BRIEF.md
# Dual-Port Interleaved Bank Memory

This block is a word-addressed data store split into a power-of-two number of independent banks, so that two requesters can be served in the same clock cycle. The low-order bits of each word address pick the bank and the remaining bits pick the row inside it. Consecutive words therefore fall into consecutive banks. With two banks, even words live in bank 0 and odd words in bank 1.

Two request ports each present a request strobe, a write enable, an address and write data. Each port gets a same-cycle grant back. A port without a grant has to hold its request and try again on a later cycle. When both ports aim at the same bank, port 0 has priority. A granted access keeps its bank occupied for a parameterised number of cycles. A granted read comes back on the port that issued it, flagged by that port's read-valid strobe, after exactly that many cycles. Because every access takes the same fixed latency, each port sees its responses in the order its reads were granted.

Top module: `dp_banked_mem`

## Requirements
- R1: The bank index is the word address modulo NBANK, taken from its low log2(NBANK) bits. The row is the address shifted right by that many bits. With NBANK=2, even addresses use bank 0 and odd addresses use bank 1.
- R2: When both ports request in the same cycle, target different banks and neither bank is occupied, both grants are high in that cycle.
- R3: When both ports request the same bank in one cycle, port 0 is granted if the bank is free. Port 1's grant is low in that cycle.
- R4: A bank that accepts an access in cycle k refuses every request in cycles k+1 to k+LAT-1. It accepts again in cycle k+LAT.
- R5: A read granted in cycle k raises the read-valid of the same port for exactly one cycle, in cycle k+LAT, with the word stored at that address. The other port's read-valid stays low for that read.
- R6: A granted write stores its data in that cycle and never raises a read-valid.
- R7: A request whose grant is low has no effect. A refused write leaves the stored word unchanged.
- R8: Reads on one port that alternate between banks can be granted on every cycle when LAT is no greater than NBANK. Their data returns one word per cycle, in grant order.
- R9: While reset is low, both read-valids are low. Reads still in flight when reset is asserted never produce a response. Stored words survive reset.
- R10: A grant is never high without its own port's request. The number of banks accepting an access in a cycle equals the number of grants in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_req | input | 1 | Port 0 request strobe |
| p0_we | input | 1 | Port 0 write enable (1 = write, 0 = read) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_gnt | output | 1 | Port 0 request accepted this cycle |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_req | input | 1 | Port 1 request strobe |
| p1_we | input | 1 | Port 1 write enable (1 = write, 0 = read) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_gnt | output | 1 | Port 1 request accepted this cycle |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | DATA_W | Port 1 read data |

## Verification
Grants are combinational, so they are due in the same cycle as the request. The bench reads them one time unit after driving inputs on the falling edge, before the next rising edge commits the access. Read data is due exactly LAT rising edges after the grant cycle. Each scenario counts falling edges from its own grant and checks read-valid low on every intermediate cycle, high with the expected word on cycle k+LAT, and low again afterwards. Bank refusal is checked on the cycles between acceptance and k+LAT. Expected words come from a model of the memory kept by the bench and indexed by plain word address.

// File: rtl/dpbm_pkg.sv
package dpbm_pkg;

  // Requester identity carried with each bank access
  typedef logic port_id_t;
  localparam port_id_t PORT0 = 1'b0;
  localparam port_id_t PORT1 = 1'b1;

  // Bank index: low bits of the word address
  function automatic int unsigned bank_of(input int unsigned addr, input int unsigned bbits);
    return addr & ((32'd1 << bbits) - 32'd1);
  endfunction

  // Row inside the bank: remaining upper bits
  function automatic int unsigned row_of(input int unsigned addr, input int unsigned bbits);
    return addr >> bbits;
  endfunction

endpackage

// File: rtl/dpbm_req_xbar.sv
module dpbm_req_xbar #(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int BB    = $clog2(NBANK),
  localparam int ROW_W = ADDR_W - BB
) (
  input  logic                         p0_req,
  input  logic                         p0_we,
  input  logic [ADDR_W-1:0]            p0_addr,
  input  logic [DATA_W-1:0]            p0_wdata,
  input  logic                         p1_req,
  input  logic                         p1_we,
  input  logic [ADDR_W-1:0]            p1_addr,
  input  logic [DATA_W-1:0]            p1_wdata,
  input  logic [NBANK-1:0]             bank_busy,
  output logic                         p0_gnt,
  output logic                         p1_gnt,
  output logic                         conflict,
  output logic [BB-1:0]                p0_bank,
  output logic [BB-1:0]                p1_bank,
  output logic [NBANK-1:0]             acc,
  output logic [NBANK-1:0]             acc_we,
  output logic [NBANK-1:0][ROW_W-1:0]  acc_row,
  output logic [NBANK-1:0][DATA_W-1:0] acc_wdata,
  output logic [NBANK-1:0]             acc_port
);
  import dpbm_pkg::*;

  logic [ROW_W-1:0] p0_row, p1_row;

  assign p0_bank = BB'(bank_of(32'(p0_addr), BB));
  assign p1_bank = BB'(bank_of(32'(p1_addr), BB));
  assign p0_row  = ROW_W'(row_of(32'(p0_addr), BB));
  assign p1_row  = ROW_W'(row_of(32'(p1_addr), BB));

  // Same-bank collision: port 0 keeps priority
  assign conflict = p0_req && p1_req && (p0_bank == p1_bank);
  assign p0_gnt   = p0_req && !bank_busy[p0_bank];
  assign p1_gnt   = p1_req && !bank_busy[p1_bank] && !conflict;

  // Per-bank steering of the winning request
  for (genvar b = 0; b < NBANK; b++) begin : g_steer
    logic from0, from1;
    assign from0 = p0_gnt && (p0_bank == BB'(b));
    assign from1 = p1_gnt && (p1_bank == BB'(b));
    assign acc[b]       = from0 || from1;
    assign acc_port[b]  = from0 ? PORT0 : PORT1;
    assign acc_we[b]    = from0 ? p0_we    : p1_we;
    assign acc_row[b]   = from0 ? p0_row   : p1_row;
    assign acc_wdata[b] = from0 ? p0_wdata : p1_wdata;
  end

endmodule

// File: rtl/dpbm_bank.sv
module dpbm_bank #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 16,
  parameter int LAT    = 2,
  localparam int DEPTH = 1 << ROW_W,
  localparam int CW    = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  input  logic              port,
  output logic              busy,
  output logic              rsp_v,
  output logic              rsp_port,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              rd_q;
  logic              port_q;
  logic [DATA_W-1:0] data_q;

  // Occupancy countdown: loaded at acceptance, response on its last cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rd_q   <= 1'b0;
      port_q <= 1'b0;
    end else if (acc) begin
      cnt    <= CW'(LAT);
      rd_q   <= !we;
      port_q <= port;
    end else if (cnt != '0) begin
      cnt    <= cnt - CW'(1);
    end
  end

  // Storage: write commits on acceptance, read word captured on acceptance
  always_ff @(posedge clk) begin
    if (acc && we)  mem[row] <= wdata;
    if (acc && !we) data_q   <= mem[row];
  end

  // Final countdown cycle may overlap the next acceptance
  assign busy     = cnt > CW'(1);
  assign rsp_v    = (cnt == CW'(1)) && rd_q;
  assign rsp_port = port_q;
  assign rsp_data = data_q;

endmodule

// File: rtl/dpbm_rsp_xbar.sv
module dpbm_rsp_xbar #(
  parameter int NBANK  = 2,
  parameter int DATA_W = 16
) (
  input  logic [NBANK-1:0]             rsp_v,
  input  logic [NBANK-1:0]             rsp_port,
  input  logic [NBANK-1:0][DATA_W-1:0] rsp_data,
  output logic [NBANK-1:0]             hit0,
  output logic [NBANK-1:0]             hit1,
  output logic                         p0_rvalid,
  output logic [DATA_W-1:0]            p0_rdata,
  output logic                         p1_rvalid,
  output logic [DATA_W-1:0]            p1_rdata
);
  import dpbm_pkg::*;

  for (genvar b = 0; b < NBANK; b++) begin : g_route
    assign hit0[b] = rsp_v[b] && (rsp_port[b] == PORT0);
    assign hit1[b] = rsp_v[b] && (rsp_port[b] == PORT1);
  end

  assign p0_rvalid = |hit0;
  assign p1_rvalid = |hit1;

  // At most one bank answers a given port per cycle, so OR-merge is safe
  always_comb begin
    p0_rdata = '0;
    p1_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit0[b]) p0_rdata = p0_rdata | rsp_data[b];
      if (hit1[b]) p1_rdata = p1_rdata | rsp_data[b];
    end
  end

endmodule

// File: rtl/dp_banked_mem.sv
module dp_banked_mem #(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LAT    = 2,
  localparam int BB    = $clog2(NBANK),
  localparam int ROW_W = ADDR_W - BB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_gnt,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_gnt,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata
);

  // Named internal events
  logic                         conflict;
  logic [BB-1:0]                p0_bank, p1_bank;
  logic                         p0_tgt_busy, p1_tgt_busy;
  logic [NBANK-1:0]             bank_busy;
  logic [NBANK-1:0]             bank_acc;
  logic [NBANK-1:0]             acc_we;
  logic [NBANK-1:0][ROW_W-1:0]  acc_row;
  logic [NBANK-1:0][DATA_W-1:0] acc_wdata;
  logic [NBANK-1:0]             acc_port;
  logic [NBANK-1:0]             rsp_v;
  logic [NBANK-1:0]             rsp_port;
  logic [NBANK-1:0][DATA_W-1:0] rsp_data;
  logic [NBANK-1:0]             hit0, hit1;

  assign p0_tgt_busy = bank_busy[p0_bank];
  assign p1_tgt_busy = bank_busy[p1_bank];

  dpbm_req_xbar #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .p0_req    (p0_req),
    .p0_we     (p0_we),
    .p0_addr   (p0_addr),
    .p0_wdata  (p0_wdata),
    .p1_req    (p1_req),
    .p1_we     (p1_we),
    .p1_addr   (p1_addr),
    .p1_wdata  (p1_wdata),
    .bank_busy (bank_busy),
    .p0_gnt    (p0_gnt),
    .p1_gnt    (p1_gnt),
    .conflict  (conflict),
    .p0_bank   (p0_bank),
    .p1_bank   (p1_bank),
    .acc       (bank_acc),
    .acc_we    (acc_we),
    .acc_row   (acc_row),
    .acc_wdata (acc_wdata),
    .acc_port  (acc_port)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dpbm_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(LAT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (bank_acc[b]),
      .we       (acc_we[b]),
      .row      (acc_row[b]),
      .wdata    (acc_wdata[b]),
      .port     (acc_port[b]),
      .busy     (bank_busy[b]),
      .rsp_v    (rsp_v[b]),
      .rsp_port (rsp_port[b]),
      .rsp_data (rsp_data[b])
    );
  end

  dpbm_rsp_xbar #(.NBANK(NBANK), .DATA_W(DATA_W)) u_rsp (
    .rsp_v     (rsp_v),
    .rsp_port  (rsp_port),
    .rsp_data  (rsp_data),
    .hit0      (hit0),
    .hit1      (hit1),
    .p0_rvalid (p0_rvalid),
    .p0_rdata  (p0_rdata),
    .p1_rvalid (p1_rvalid),
    .p1_rdata  (p1_rdata)
  );

endmodule

// File: rtl/dpbm_chk.sv
module dpbm_chk #(
  parameter int NBANK = 2,
  parameter int LAT   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             p0_req,
  input logic             p0_we,
  input logic             p0_gnt,
  input logic             p0_rvalid,
  input logic             p1_req,
  input logic             p1_we,
  input logic             p1_gnt,
  input logic             p1_rvalid,
  input logic             conflict,
  input logic             p0_tgt_busy,
  input logic             p1_tgt_busy,
  input logic [NBANK-1:0] bank_busy,
  input logic [NBANK-1:0] bank_acc,
  input logic [NBANK-1:0] hit0,
  input logic [NBANK-1:0] hit1
);

  // Read-grant history per port, LAT deep
  logic [LAT-1:0] pend0, pend1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend0 <= '0;
      pend1 <= '0;
    end else begin
      pend0[0] <= p0_gnt && !p0_we;
      pend1[0] <= p1_gnt && !p1_we;
      for (int i = 1; i < LAT; i++) begin
        pend0[i] <= pend0[i-1];
        pend1[i] <= pend1[i-1];
      end
    end
  end

  a_r2_parallel_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && p1_req && !conflict && !p0_tgt_busy && !p1_tgt_busy) |-> (p0_gnt && p1_gnt));

  a_r3_conflict_holds_p1: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> !p1_gnt);

  a_r3_p0_wins_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && !p0_tgt_busy) |-> p0_gnt);

  a_r4_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_acc & bank_busy) == '0);

  if (LAT > 1) begin : g_busy
    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_acc != '0) |=> ((bank_busy & $past(bank_acc)) == $past(bank_acc)));
  end

  a_r5_p0_latency: assert property (@(posedge clk) disable iff (!rst_n)
    p0_rvalid == pend0[LAT-1]);

  a_r5_p1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    p1_rvalid == pend1[LAT-1]);

  a_r8_single_source_p0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit0));

  a_r8_single_source_p1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit1));

  a_r10_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_gnt |-> p0_req) and (p1_gnt |-> p1_req));

  a_r10_accept_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_acc) == (32'(p0_gnt) + 32'(p1_gnt)));

endmodule

bind dp_banked_mem dpbm_chk #(.NBANK(NBANK), .LAT(LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .p0_req      (p0_req),
  .p0_we       (p0_we),
  .p0_gnt      (p0_gnt),
  .p0_rvalid   (p0_rvalid),
  .p1_req      (p1_req),
  .p1_we       (p1_we),
  .p1_gnt      (p1_gnt),
  .p1_rvalid   (p1_rvalid),
  .conflict    (conflict),
  .p0_tgt_busy (p0_tgt_busy),
  .p1_tgt_busy (p1_tgt_busy),
  .bank_busy   (bank_busy),
  .bank_acc    (bank_acc),
  .hit0        (hit0),
  .hit1        (hit1)
);

// File: tb/dp_banked_mem_tb.sv
module dp_banked_mem_tb;

  localparam int NBANK  = 2;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              p0_req = 1'b0, p0_we = 1'b0, p1_req = 1'b0, p1_we = 1'b0;
  logic [ADDR_W-1:0] p0_addr = '0, p1_addr = '0;
  logic [DATA_W-1:0] p0_wdata = '0, p1_wdata = '0;
  logic              p0_gnt, p0_rvalid, p1_gnt, p1_rvalid;
  logic [DATA_W-1:0] p0_rdata, p1_rdata;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model [1 << ADDR_W];

  always #4 clk = ~clk;

  dp_banked_mem #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_gnt(p0_gnt), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_gnt(p1_gnt), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Drive one cycle's inputs on the falling edge, settle, return
  task automatic drv(input bit r0, input bit w0, input logic [ADDR_W-1:0] a0, input logic [DATA_W-1:0] d0,
                     input bit r1, input bit w1, input logic [ADDR_W-1:0] a1, input logic [DATA_W-1:0] d1);
    @(negedge clk);
    p0_req = r0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
    p1_req = r1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
    #1;
  endtask

  task automatic idle();
    drv(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  function automatic logic [DATA_W-1:0] seed_val(input int a);
    return DATA_W'(16'hC300 ^ (a * 16'h0107));
  endfunction

  task automatic t_reset();
    idle();
    chk(!p0_rvalid && !p1_rvalid, "R9 rvalid low in reset", {p0_rvalid, p1_rvalid}, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // Even words from port 0, odd words from port 1, same cycle
  task automatic t_seed();
    for (int i = 0; i < 16; i += 2) begin
      drv(1, 1, ADDR_W'(i), seed_val(i), 1, 1, ADDR_W'(i + 1), seed_val(i + 1));
      model[i] = seed_val(i);
      model[i + 1] = seed_val(i + 1);
      chk(p0_gnt && p1_gnt, "R2 split banks both granted", {p0_gnt, p1_gnt}, 2'b11);
      for (int k = 1; k < LAT; k++) begin
        idle();
        chk(!p0_rvalid && !p1_rvalid, "R6 write gives no rvalid", {p0_rvalid, p1_rvalid}, 0);
      end
    end
    idle();
    chk(!p0_rvalid && !p1_rvalid, "R6 write gives no rvalid", {p0_rvalid, p1_rvalid}, 0);
  endtask

  // Port 0 reads an odd word, port 1 an even word: crossbar swap
  task automatic t_cross_read();
    drv(1, 0, 6'd3, '0, 1, 0, 6'd4, '0);
    chk(p0_gnt && p1_gnt, "R2 crossed reads granted", {p0_gnt, p1_gnt}, 2'b11);
    for (int k = 1; k <= LAT; k++) begin
      idle();
      if (k < LAT) begin
        chk(!p0_rvalid && !p1_rvalid, "R5 no early response", {p0_rvalid, p1_rvalid}, 0);
      end else begin
        chk(p0_rvalid && p0_rdata == model[3], "R5 R1 port0 word 3", {15'd0, p0_rvalid, p0_rdata}, {16'd1, model[3]});
        chk(p1_rvalid && p1_rdata == model[4], "R5 R1 port1 word 4", {15'd0, p1_rvalid, p1_rdata}, {16'd1, model[4]});
      end
    end
    idle();
    chk(!p0_rvalid && !p1_rvalid, "R5 single-cycle response", {p0_rvalid, p1_rvalid}, 0);
  endtask

  // Words 2 and 6 share bank 0; port 1 write is refused and must not land
  task automatic t_conflict();
    drv(1, 0, 6'd2, '0, 1, 1, 6'd6, 16'hDEAD);
    chk(p0_gnt, "R3 port0 wins conflict", p0_gnt, 1);
    chk(!p1_gnt, "R3 port1 held on conflict", p1_gnt, 0);
    drv(0, 0, '0, '0, 1, 0, 6'd6, '0);
    chk(!p1_gnt, "R4 busy bank refuses", p1_gnt, 0);
    drv(0, 0, '0, '0, 1, 0, 6'd6, '0);
    chk(p1_gnt, "R4 bank free at k+LAT", p1_gnt, 1);
    chk(p0_rvalid && p0_rdata == model[2], "R5 port0 word 2", {15'd0, p0_rvalid, p0_rdata}, {16'd1, model[2]});
    chk(!p1_rvalid, "R5 no response on other port", p1_rvalid, 0);
    idle();
    idle();
    chk(p1_rvalid && p1_rdata == model[6], "R7 refused write left word 6", {15'd0, p1_rvalid, p1_rdata}, {16'd1, model[6]});
    idle();
  endtask

  // Write then read back the same word from the other port
  task automatic t_raw();
    drv(1, 1, 6'd5, 16'h5A5A, 0, 0, '0, '0);
    model[5] = 16'h5A5A;
    chk(p0_gnt, "R6 write granted", p0_gnt, 1);
    for (int k = 1; k < LAT; k++) idle();
    drv(0, 0, '0, '0, 1, 0, 6'd5, '0);
    chk(p1_gnt, "R4 reaccept after write", p1_gnt, 1);
    for (int k = 1; k <= LAT; k++) idle();
    chk(p1_rvalid && p1_rdata == 16'h5A5A, "R6 written word read back", {15'd0, p1_rvalid, p1_rdata}, {16'd1, 16'h5A5A});
    idle();
  endtask

  // Back-to-back reads alternating banks on one port
  task automatic t_stream(input bit port);
    for (int i = 0; i < 4 + LAT; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(8 + i);
      if (i < 4) begin
        if (port) drv(0, 0, '0, '0, 1, 0, a, '0);
        else      drv(1, 0, a, '0, 0, 0, '0, '0);
        chk(port ? p1_gnt : p0_gnt, "R8 stream granted each cycle", port ? p1_gnt : p0_gnt, 1);
      end else begin
        idle();
      end
      if (i >= LAT) begin
        logic v;
        logic [DATA_W-1:0] d;
        v = port ? p1_rvalid : p0_rvalid;
        d = port ? p1_rdata  : p0_rdata;
        chk(v && d == model[8 + i - LAT], "R8 in-order stream data", {15'd0, v, d}, {16'd1, model[8 + i - LAT]});
      end
      chk(!(port ? p0_rvalid : p1_rvalid), "R5 idle port silent", port ? p0_rvalid : p1_rvalid, 0);
    end
    idle();
  endtask

  // Reset with a read in flight: response dropped, storage kept
  task automatic t_reset_flush();
    drv(1, 0, 6'd7, '0, 0, 0, '0, '0);
    chk(p0_gnt, "R9 read granted before reset", p0_gnt, 1);
    @(negedge clk);
    p0_req = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!p0_rvalid, "R9 in-flight read dropped", p0_rvalid, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < LAT; k++) begin
      idle();
      chk(!p0_rvalid && !p1_rvalid, "R9 no response after reset", {p0_rvalid, p1_rvalid}, 0);
    end
    drv(1, 0, 6'd7, '0, 0, 0, '0, '0);
    for (int k = 1; k <= LAT; k++) idle();
    chk(p0_rvalid && p0_rdata == model[7], "R9 storage kept", {15'd0, p0_rvalid, p0_rdata}, {16'd1, model[7]});
    idle();
  endtask

  // Grants without request must stay low
  task automatic t_no_req();
    drv(0, 0, 6'd1, '0, 0, 0, 6'd2, '0);
    chk(!p0_gnt && !p1_gnt, "R10 no grant without request", {p0_gnt, p1_gnt}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_req();
    t_seed();
    t_cross_read();
    t_conflict();
    t_raw();
    t_stream(1'b0);
    t_stream(1'b1);
    t_reset_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule